// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt Logic

This block watches the running date and time delivered by a separate time-keeping counter. It raises an alarm when the programmed alarm value agrees with that date and time. Seven fields take part: second, minute, hour, weekday, day of month, month and year. Each field has its own include bit, so an alarm can be as narrow as one exact instant or as broad as "every minute at second 0". A master arm bit gates the whole comparison. While it is set and no field is included, the alarm matches on every cycle.

The comparison result is registered into a raw interrupt flag. That flag is combined with an interrupt enable and a software force bit to give the interrupt line. Software reaches the alarm values, the include bits, the master arm bit, an armed indicator and the interrupt bits through a small word-addressed register port. Writes are synchronous and reads are combinational. Reset is asserted asynchronously (active low) and released synchronously through a two-stage synchroniser.

Top module: `cal_alarm_irq`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Address 0 holds day in [4:0], month in [11:8] and year in [27:16]. Address 1 holds second in [5:0], minute in [13:8], hour in [20:16] and weekday in [26:24]. All other bits of these two words read zero.
- R3: Address 2 holds the field include mask in [6:0], the master arm bit in [8] and the armed indicator in [9]. Mask bit 0 is second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month and 6 year.
- R4: With the master arm bit set and every included field equal to its current input, the raw flag (address 3, bit 0) is 1 one cycle later.
- R5: A field whose include bit is clear has no effect on the result: a mismatch in that field alone still yields a match.
- R6: With the master arm bit clear, the raw flag is 0 one cycle later, whatever the fields are.
- R7: With the master arm bit set and the mask all zero, the raw flag is 1 on every cycle.
- R8: The raw flag stays high while the match holds and drops one cycle after any included field stops matching.
- R9: The armed indicator equals the master arm bit with a delay of one cycle.
- R10: `irq` and the status bit (address 6, bit 0) equal (raw AND enable) OR force. Enable is address 4 bit 0 and force is address 5 bit 0.
- R11: Writes to the raw flag, the status word and the armed bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_year | input | 12 | Current year |
| cur_month | input | 4 | Current month |
| cur_day | input | 5 | Current day of month |
| cur_wday | input | 3 | Current weekday |
| cur_hour | input | 5 | Current hour |
| cur_min | input | 6 | Current minute |
| cur_sec | input | 6 | Current second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A write takes effect at the clock edge that samples it. The raw flag and the armed indicator settle one edge after their cause, whether that cause is a register write or a change of the date and time inputs. `irq` and the status word follow the enable and force bits within the same cycle as the register update. The bench drives all inputs on the falling edge and samples at the falling edge that follows the edge where each result is due. It also checks the armed indicator at the intermediate falling edge, where it must still hold the old value. The main sweep covers all 128 include masks against a full match and against a single-field mismatch in each of the seven fields.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFIELD = 7;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int WDAY_W = 3;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 12;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int ARM_BIT   = 8;
  localparam int ARMED_BIT = 9;

  // field order: sec, min, hour, wday, day, month, year (LSB first)
  localparam int FW [NFIELD] = '{SEC_W, MIN_W, HOUR_W, WDAY_W, DAY_W, MON_W, YEAR_W};

  function automatic int foff(input int idx);
    int s;
    s = 0;
    for (int j = 0; j < idx; j++) s += FW[j];
    return s;
  endfunction

  localparam int TIME_W = foff(NFIELD);

  typedef enum logic [ADDR_W-1:0] {
    A_DATE = 3'd0,
    A_TIME = 3'd1,
    A_CTRL = 3'd2,
    A_RAW  = 3'd3,
    A_IEN  = 3'd4,
    A_FRC  = 3'd5,
    A_STAT = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TIME_W-1:0] alm_flat,
  output logic [NFIELD-1:0] fld_en,
  output logic              glob_en,
  output logic              irq_en,
  output logic              irq_force
);
  logic [TIME_W-1:0] alm_d;
  logic [NFIELD-1:0] fld_en_d;
  logic              glob_en_d, irq_en_d, irq_force_d;

  always_comb begin
    alm_d       = alm_flat;
    fld_en_d    = fld_en;
    glob_en_d   = glob_en;
    irq_en_d    = irq_en;
    irq_force_d = irq_force;
    if (wr_en) begin
      case (wr_addr)
        A_DATE: begin
          alm_d[foff(4) +: DAY_W]  = wr_data[0  +: DAY_W];
          alm_d[foff(5) +: MON_W]  = wr_data[8  +: MON_W];
          alm_d[foff(6) +: YEAR_W] = wr_data[16 +: YEAR_W];
        end
        A_TIME: begin
          alm_d[foff(0) +: SEC_W]  = wr_data[0  +: SEC_W];
          alm_d[foff(1) +: MIN_W]  = wr_data[8  +: MIN_W];
          alm_d[foff(2) +: HOUR_W] = wr_data[16 +: HOUR_W];
          alm_d[foff(3) +: WDAY_W] = wr_data[24 +: WDAY_W];
        end
        A_CTRL: begin
          fld_en_d  = wr_data[NFIELD-1:0];
          glob_en_d = wr_data[ARM_BIT];
        end
        A_IEN:   irq_en_d    = wr_data[0];
        A_FRC:   irq_force_d = wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_flat  <= '0;
      fld_en    <= '0;
      glob_en   <= 1'b0;
      irq_en    <= 1'b0;
      irq_force <= 1'b0;
    end else begin
      alm_flat  <= alm_d;
      fld_en    <= fld_en_d;
      glob_en   <= glob_en_d;
      irq_en    <= irq_en_d;
      irq_force <= irq_force_d;
    end
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic [TIME_W-1:0] cur_flat,
  input  logic [TIME_W-1:0] alm_flat,
  input  logic [NFIELD-1:0] fld_en,
  input  logic              glob_en,
  output logic              match
);
  logic [NFIELD-1:0] hit;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam int OFF = foff(i);
    localparam int W   = FW[i];
    assign hit[i] = !fld_en[i] || (cur_flat[OFF +: W] == alm_flat[OFF +: W]);
  end

  assign match = glob_en && (&hit);
endmodule

// File: rtl/cal_alarm_irq_ctl.sv
module cal_alarm_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic glob_en,
  input  logic irq_en,
  input  logic irq_force,
  output logic raw,
  output logic armed,
  output logic irq
);
  logic raw_d, armed_d;

  always_comb begin
    raw_d   = match;
    armed_d = glob_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw   <= 1'b0;
      armed <= 1'b0;
    end else begin
      raw   <= raw_d;
      armed <= armed_d;
    end
  end

  assign irq = (raw && irq_en) || irq_force;
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [YEAR_W-1:0] cur_year,
  input  logic [MON_W-1:0]  cur_month,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [TIME_W-1:0] cur_flat, alm_flat;
  logic [NFIELD-1:0] fld_en;
  logic              glob_en, irq_en, irq_force, match, raw, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign cur_flat = {cur_year, cur_month, cur_day, cur_wday, cur_hour, cur_min, cur_sec};

  cal_alarm_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alm_flat(alm_flat), .fld_en(fld_en),
    .glob_en(glob_en), .irq_en(irq_en), .irq_force(irq_force)
  );

  cal_alarm_cmp u_cmp (
    .cur_flat(cur_flat), .alm_flat(alm_flat), .fld_en(fld_en),
    .glob_en(glob_en), .match(match)
  );

  cal_alarm_irq_ctl u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .match(match), .glob_en(glob_en),
    .irq_en(irq_en), .irq_force(irq_force), .raw(raw), .armed(armed),
    .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_DATE: begin
        rd_data[0  +: DAY_W]  = alm_flat[foff(4) +: DAY_W];
        rd_data[8  +: MON_W]  = alm_flat[foff(5) +: MON_W];
        rd_data[16 +: YEAR_W] = alm_flat[foff(6) +: YEAR_W];
      end
      A_TIME: begin
        rd_data[0  +: SEC_W]  = alm_flat[foff(0) +: SEC_W];
        rd_data[8  +: MIN_W]  = alm_flat[foff(1) +: MIN_W];
        rd_data[16 +: HOUR_W] = alm_flat[foff(2) +: HOUR_W];
        rd_data[24 +: WDAY_W] = alm_flat[foff(3) +: WDAY_W];
      end
      A_CTRL: begin
        rd_data[NFIELD-1:0] = fld_en;
        rd_data[ARM_BIT]    = glob_en;
        rd_data[ARMED_BIT]  = armed;
      end
      A_RAW:   rd_data[0] = raw;
      A_IEN:   rd_data[0] = irq_en;
      A_FRC:   rd_data[0] = irq_force;
      A_STAT:  rd_data[0] = irq;
      default: ;
    endcase
  end
endmodule

// File: rtl/cal_alarm_irq_chk.sv
module cal_alarm_irq_chk
  import cal_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              glob_en,
  input logic [NFIELD-1:0] fld_en,
  input logic              armed,
  input logic              raw,
  input logic              irq_force,
  input logic              irq
);
  a_r9_arm_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glob_en) |=> armed);
  a_r9_arm_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glob_en) |=> !armed);
  a_r7_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && fld_en == '0) |=> raw);
  a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !raw);
  a_r10_force: assert property (@(posedge clk) disable iff (!rst_n)
    irq_force |-> irq);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_force && !raw) |-> !irq);
endmodule

bind cal_alarm_irq cal_alarm_irq_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .glob_en(glob_en), .fld_en(fld_en),
  .armed(armed), .raw(raw), .irq_force(irq_force), .irq(irq)
);

// File: tb/cal_alarm_irq_bench.sv
`timescale 1ns/1ps
module cal_alarm_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cur_year = '0;
  logic [3:0]  cur_month = '0;
  logic [4:0]  cur_day = '0;
  logic [2:0]  cur_wday = '0;
  logic [4:0]  cur_hour = '0;
  logic [5:0]  cur_min = '0;
  logic [5:0]  cur_sec = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cal_alarm_irq u_cal_alarm_irq (
    .clk(clk), .rst_n(rst_n), .cur_year(cur_year), .cur_month(cur_month),
    .cur_day(cur_day), .cur_wday(cur_wday), .cur_hour(cur_hour),
    .cur_min(cur_min), .cur_sec(cur_sec), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  // base date/time: 2024-09-17, weekday 4, 13:45:30; k<7 bumps field k by one
  task automatic set_cur(input int k);
    cur_sec   = 6'd30;  cur_min  = 6'd45; cur_hour  = 5'd13; cur_wday = 3'd4;
    cur_day   = 5'd17;  cur_month = 4'd9; cur_year  = 12'd2024;
    case (k)
      0: cur_sec   = 6'd31;
      1: cur_min   = 6'd46;
      2: cur_hour  = 5'd14;
      3: cur_wday  = 3'd5;
      4: cur_day   = 5'd18;
      5: cur_month = 4'd10;
      6: cur_year  = 12'd2025;
      default: ;
    endcase
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], v);
      chk("R1 reset readback", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2 layout with junk in unused bits
    wr(3'd0, 32'hF7E8F9F1);
    rd(3'd0, v); chk("R2 date word", v, 32'h07E80911);
    wr(3'd1, 32'hFC2DED1E);
    rd(3'd1, v); chk("R2 time word", v, 32'h040D2D1E);

    // R3/R9 control word and armed delay
    wr(3'd2, 32'h0000017F);
    rd(3'd2, v); chk("R3 ctrl before armed", v, 32'h0000017F);
    @(negedge clk);
    rd(3'd2, v); chk("R9 armed one cycle later", v, 32'h0000037F);
    wr(3'd2, 32'h0000007F);
    rd(3'd2, v); chk("R9 armed still set", v, 32'h0000027F);
    @(negedge clk);
    rd(3'd2, v); chk("R9 armed cleared", v, 32'h0000007F);

    // R11 writes to read-only bits ignored
    wr(3'd2, 32'h0000027F);
    @(negedge clk);
    rd(3'd2, v); chk("R11 armed not writable", v, 32'h0000007F);
    wr(3'd3, 32'h1);
    wr(3'd6, 32'h1);
    @(negedge clk);
    rd(3'd3, v); chk("R11 raw not writable", v, 32'h0);
    rd(3'd6, v); chk("R11 stat not writable", v, 32'h0);
    chk("R11 irq stays low", {31'b0, irq}, 32'h0);

    // alarm = day 17 month 9 year 2024, wday 4 13:45:30
    wr(3'd0, 32'h07E80911);
    wr(3'd1, 32'h040D2D1E);

    // R4/R5/R7 sweep all masks against full match and single-field mismatch
    for (int m = 0; m < 128; m++) begin
      wr(3'd2, 32'h100 | m);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        set_cur(k);
        @(negedge clk);
        rd(3'd3, v);
        if (k == 7)     chk("R4 full match", v, 32'h1);
        else if (m == 0) chk("R7 empty mask matches", v, 32'h1);
        else            chk("R5 mask vs field mismatch", v, {31'b0, !m[k]});
      end
    end

    // R6 master arm clear
    for (int k = 0; k < 8; k++) begin
      wr(3'd2, 32'h0000007F);
      set_cur(k);
      @(negedge clk);
      @(negedge clk);
      rd(3'd3, v); chk("R6 disarmed no raw", v, 32'h0);
    end

    // R8 hold then release
    set_cur(7);
    wr(3'd2, 32'h0000017F);
    @(negedge clk);
    rd(3'd3, v); chk("R8 raw set", v, 32'h1);
    @(negedge clk);
    rd(3'd3, v); chk("R8 raw held", v, 32'h1);
    set_cur(0);
    rd(3'd3, v); chk("R8 raw not yet cleared", v, 32'h1);
    @(negedge clk);
    rd(3'd3, v); chk("R8 raw cleared after mismatch", v, 32'h0);
    set_cur(7);
    @(negedge clk);
    wr(3'd2, 32'h0000007F);
    @(negedge clk);
    rd(3'd3, v); chk("R6 raw clears on disarm", v, 32'h0);

    // R10 raw x enable x force
    for (int c = 0; c < 8; c++) begin
      wr(3'd2, c[0] ? 32'h100 : 32'h0);
      wr(3'd4, {31'b0, c[1]});
      wr(3'd5, {31'b0, c[2]});
      @(negedge clk);
      rd(3'd6, v);
      chk("R10 status word", v, {31'b0, (c[0] & c[1]) | c[2]});
      chk("R10 irq pin", {31'b0, irq}, {31'b0, (c[0] & c[1]) | c[2]});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule